// File: doc/BRIEF.md
# Prioritized DMA Interrupt Vector Generator

This block forms the interrupt vector that a DMA engine hands back when the processor runs an interrupt acknowledge read. The interrupt sources fall into two groups. The task group has sixteen task pending lines. The unit group has eight execution-unit pending lines, a bus-error line and a debug line. Every source has its own mask bit, and a mask bit of 1 silences that source. Each group is priority-encoded into a 4-bit low nibble. That nibble is joined with a software-programmed high nibble to make one 8-bit vector per group.

Software sets the two high nibbles through a small write port. A select bit on that port picks which vector's nibble is written. Both vectors are held in registers and can be read together as a 16-bit status word. When the acknowledge strobe is sampled high, the block latches one of the two vectors onto its acknowledge output. It picks the task vector whenever any unmasked task interrupt is active, and the unit vector otherwise. A group that has no unmasked active source reports the sentinel low nibble 4'hF.

Top module: `dma_ivec_gen`

## Requirements
- R1: A write with `cfg_we`=1 loads `cfg_nibble` into the high nibble of vector 1 when `cfg_sel`=0, or of vector 2 when `cfg_sel`=1. The new nibble appears in bits [7:4] of that vector one clock after the write edge.
- R2: The low nibble of vector 1 equals the index of the highest-numbered task bit that is both pending and unmasked. Task bit 15 has the highest priority.
- R3: The low nibble of vector 2 is 9 for debug and 8 for bus error. For execution unit n it is n. Priority runs from debug, to bus error, then from unit 7 down to unit 0.
- R4: A source whose mask bit is 1 never affects either low nibble.
- R5: A group with no unmasked pending source reports the low nibble 4'hF.
- R6: If `ack` is sampled high while any unmasked task interrupt was active in the previous cycle, `ack_vec` takes the value of vector 1.
- R7: If `ack` is sampled high while no unmasked task interrupt was active, `ack_vec` takes vector 2. This holds even when vector 2 carries the sentinel.
- R8: While `rst` is high, both vectors and `ack_vec` read 8'h0F, and `status` reads 16'h0F0F.
- R9: The vectors are registered. A change on the pending or mask inputs is not visible on `status` until the next rising clock edge.
- R10: `ack_vec` holds its value on every edge where `ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| task_pend | input | 16 | Task interrupt pending lines |
| task_mask | input | 16 | Task mask, 1 disables the source |
| eu_pend | input | 8 | Execution-unit pending lines |
| eu_mask | input | 8 | Execution-unit mask, 1 disables the source |
| berr_pend | input | 1 | Bus-error pending |
| berr_mask | input | 1 | Bus-error mask |
| dbg_pend | input | 1 | Debug pending |
| dbg_mask | input | 1 | Debug mask |
| cfg_we | input | 1 | High-nibble write strobe |
| cfg_sel | input | 1 | 0 selects vector 1, 1 selects vector 2 |
| cfg_nibble | input | 4 | High nibble write data |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_vec | output | 8 | Vector returned for the last acknowledge |
| status | output | 16 | {vector 1, vector 2} |

## Verification
The assertions assume that the pending and mask lines are level signals free of X, and that they are sampled once per clock. They also assume that `ack` and `cfg_we` are plain strobes whose value at an edge is all that counts. The bench changes every input only on the falling clock edge and reads the outputs on the falling edge after that. This keeps every stimulus a clean, fully known level at each rising edge. The unit group is swept through all of its request patterns. The task group and the masks are driven with arithmetic mixes and walking single bits, and the high nibbles are rewritten between batches.

// File: rtl/dma_ivec_pkg.sv
package dma_ivec_pkg;
  localparam int LO_W = 4;
  localparam int HI_W = 4;
  localparam int VEC_W = LO_W + HI_W;
  localparam logic [LO_W-1:0] NONE_CODE = '1;
  localparam logic [VEC_W-1:0] VEC_RST = {{HI_W{1'b0}}, NONE_CODE};
  typedef logic [VEC_W-1:0] ivec_t;
endpackage

// File: rtl/ivec_prio_enc.sv
module ivec_prio_enc #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic [W-1:0]  req,
  output logic [CW-1:0] code,
  output logic          any
);
  always_comb begin
    code = '1;
    any  = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) begin
        code = CW'(i);
        any  = 1'b1;
      end
    end
  end

  always_comb begin
    if (any) begin
      // R2 R3: the chosen bit is set and no higher bit is
      top_hit_chk: assert ((req >> code) == W'(1));
    end else begin
      // R5
      none_code_chk: assert (code == '1);
    end
  end
endmodule

// File: rtl/ivec_hi_regs.sv
module ivec_hi_regs #(
  parameter int HW = 4,
  parameter int NV = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [$clog2(NV)-1:0] sel,
  input  logic [HW-1:0]         wdata,
  output logic [NV-1:0][HW-1:0] hi
);
  for (genvar g = 0; g < NV; g++) begin : g_hi
    always_ff @(posedge clk) begin
      if (rst) hi[g] <= '0;
      else if (we && sel == g) hi[g] <= wdata;
    end
  end

  // R1
  hi_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> hi[$past(sel)] == $past(wdata));
endmodule

// File: rtl/dma_ivec_gen.sv
module dma_ivec_gen
  import dma_ivec_pkg::*;
#(
  parameter int NTASK = 16,
  parameter int NEU   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTASK-1:0] task_pend,
  input  logic [NTASK-1:0] task_mask,
  input  logic [NEU-1:0]   eu_pend,
  input  logic [NEU-1:0]   eu_mask,
  input  logic             berr_pend,
  input  logic             berr_mask,
  input  logic             dbg_pend,
  input  logic             dbg_mask,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [HI_W-1:0]  cfg_nibble,
  input  logic             ack,
  output logic [VEC_W-1:0] ack_vec,
  output logic [2*VEC_W-1:0] status
);
  localparam int UNIT_W = NEU + 2;

  logic [NTASK-1:0]      task_req;
  logic [UNIT_W-1:0]     unit_req;
  logic [LO_W-1:0]       task_lo, unit_lo;
  logic                  task_any, unit_any;
  logic [1:0][HI_W-1:0]  hi;
  ivec_t                 vec1_q, vec2_q;
  logic                  task_act_q, unit_act_q;

  assign task_req = task_pend & ~task_mask;
  // debug above bus error above units
  assign unit_req = {dbg_pend & ~dbg_mask, berr_pend & ~berr_mask, eu_pend & ~eu_mask};

  ivec_prio_enc #(.W(NTASK), .CW(LO_W)) u_task_enc (
    .req(task_req), .code(task_lo), .any(task_any));

  ivec_prio_enc #(.W(UNIT_W), .CW(LO_W)) u_unit_enc (
    .req(unit_req), .code(unit_lo), .any(unit_any));

  ivec_hi_regs #(.HW(HI_W), .NV(2)) u_hi (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_nibble), .hi(hi));

  always_ff @(posedge clk) begin
    if (rst) begin
      vec1_q     <= VEC_RST;
      vec2_q     <= VEC_RST;
      task_act_q <= 1'b0;
      unit_act_q <= 1'b0;
    end else begin
      vec1_q     <= {hi[0], task_lo};
      vec2_q     <= {hi[1], unit_lo};
      task_act_q <= task_any;
      unit_act_q <= unit_any;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ack_vec <= VEC_RST;
    else if (ack) ack_vec <= task_act_q ? vec1_q : vec2_q;
  end

  assign status = {vec1_q, vec2_q};

  // R6
  ack_task_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && task_act_q) |=> ack_vec == $past(status[2*VEC_W-1:VEC_W]));

  // R7
  ack_unit_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !task_act_q) |=> ack_vec == $past(status[VEC_W-1:0]));

  // R10
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ack |=> $stable(ack_vec));

  // R5
  unit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !unit_act_q |-> vec2_q[LO_W-1:0] == NONE_CODE);

  // R1
  vec1_hi_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> vec1_q[VEC_W-1:LO_W] == $past(hi[0]));
endmodule

// File: tb/tb_dma_ivec_gen.sv
`timescale 1ns/1ps
module tb_dma_ivec_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] task_pend = '0, task_mask = '0;
  logic [7:0]  eu_pend = '0, eu_mask = '0;
  logic        berr_pend = 1'b0, berr_mask = 1'b0;
  logic        dbg_pend = 1'b0, dbg_mask = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [3:0]  cfg_nibble = '0;
  logic        ack = 1'b0;
  logic [7:0]  ack_vec;
  logic [15:0] status;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [3:0] h1 = 4'h0, h2 = 4'h0;

  always #2.5 clk = ~clk;

  dma_ivec_gen dut (
    .clk(clk), .rst(rst), .task_pend(task_pend), .task_mask(task_mask),
    .eu_pend(eu_pend), .eu_mask(eu_mask), .berr_pend(berr_pend),
    .berr_mask(berr_mask), .dbg_pend(dbg_pend), .dbg_mask(dbg_mask),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_nibble(cfg_nibble),
    .ack(ack), .ack_vec(ack_vec), .status(status));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_task(input logic [15:0] r);
    for (int i = 15; i >= 0; i--)
      if (r[i]) return 4'(i);
    return 4'hF;
  endfunction

  function automatic logic [3:0] exp_unit(input logic d, input logic b, input logic [7:0] e);
    if (d) return 4'd9;
    if (b) return 4'd8;
    for (int i = 7; i >= 0; i--)
      if (e[i]) return 4'(i);
    return 4'hF;
  endfunction

  task automatic wr_hi(input logic sel, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_nibble = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) h2 = d; else h1 = d;
  endtask

  task automatic apply(input logic [15:0] tp, input logic [15:0] tm,
                       input logic [7:0] ep, input logic [7:0] em,
                       input logic dp, input logic dm,
                       input logic bp, input logic bm, input logic do_ack);
    logic [15:0] prev;
    logic [7:0]  v1, v2, av_prev, exp_ack;
    logic        tact;
    @(negedge clk);
    prev = status;
    task_pend = tp; task_mask = tm; eu_pend = ep; eu_mask = em;
    dbg_pend = dp; dbg_mask = dm; berr_pend = bp; berr_mask = bm;
    #1;
    chk("R9 no change before edge", status, prev);
    v1 = {h1, exp_task(tp & ~tm)};
    v2 = {h2, exp_unit(dp & ~dm, bp & ~bm, ep & ~em)};
    tact = |(tp & ~tm);
    @(negedge clk);
    chk("R2 R3 R4 R5 vectors", status, {v1, v2});
    av_prev = ack_vec;
    ack = do_ack;
    @(negedge clk);
    ack = 1'b0;
    exp_ack = do_ack ? (tact ? v1 : v2) : av_prev;
    if (!do_ack) chk("R10 ack_vec hold", {8'h0, ack_vec}, {8'h0, exp_ack});
    else if (tact) chk("R6 ack picks vector 1", {8'h0, ack_vec}, {8'h0, exp_ack});
    else chk("R7 ack picks vector 2", {8'h0, ack_vec}, {8'h0, exp_ack});
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : stim
    // R8: reset dominates live inputs and a write and an acknowledge
    task_pend = 16'h8001; eu_pend = 8'hFF; dbg_pend = 1'b1;
    cfg_we = 1'b1; cfg_nibble = 4'hA; ack = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 status in reset", status, 16'h0F0F);
    chk("R8 ack_vec in reset", {8'h0, ack_vec}, 16'h000F);
    cfg_we = 1'b0; ack = 1'b0;
    task_pend = '0; eu_pend = '0; dbg_pend = 1'b0;
    rst = 1'b0;

    // R1: program high nibbles
    wr_hi(1'b0, 4'h3);
    wr_hi(1'b1, 4'hC);
    apply('0, '0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1 high nibbles", {status[15:12], status[7:4]}, {8'h0, 4'h3, 4'hC});

    // R2 R6: walking task bit, unit group also busy
    for (int i = 0; i < 16; i++)
      apply(16'(1) << i, '0, 8'hFF, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);

    // R3 R7: every unit request pattern, no tasks
    for (int u = 0; u < 1024; u++)
      apply('0, '0, u[7:0], '0, u[9], 1'b0, u[8], 1'b0, 1'b1);

    // R4 R5 R10: mixed pending and masks, nibbles rewritten per batch
    for (int k = 0; k < 1200; k++) begin
      if (k % 150 == 0) begin
        wr_hi(1'b0, 4'(k / 150 + 1));
        wr_hi(1'b1, 4'(15 - k / 150));
      end
      apply(16'(k * 40503), 16'(k * 2654 + 7), 8'(k * 7), 8'((k >> 3) * 13),
            k[2], k[5], k[1], k[6], k[0] | k[3]);
    end

    // R5 R7: everything masked -> vector 2 with sentinel
    apply(16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R5 R7 sentinel on ack", {8'h0, ack_vec}, {8'h0, h2, 4'hF});

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule